// File: doc/BRIEF.md
# Standby and Wake Power-Mode Sequencer

This block steps a bridge transceiver through its power modes. After reset it passes through standby and turns on the regulators. On the first power-up only, it samples the strap pins that set the serial-port role, the clock polarity, the clock phase and the clock-rate code. It then enters normal operation. Later wake-ups skip the strap sampling, because a flag set on the first pass stays set until the next reset.

The host controls the mode through one disable pin. The pin is seen through a consecutive-cycle deglitch filter. A filtered high level in normal operation starts the sleep sequence. A filtered low level in standby wakes the block. Activity on the isolated line also wakes the block. After such a line wake-up, the sequencer pulls the disable pin low for a fixed time once normal operation is reached, which interrupts the host. When the pull-down ends and the host does not hold the pin low itself, the block goes back to sleep.

The pin level seen by the filter is the external level ANDed with the inverse of the block's own pull-down. All durations are counted in system-clock cycles.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstN` is low, `pmState` is 0 (reset), `regEnable` and `disPullDown` are 0, and all latched strap outputs are 0.
- R2: State codes are 0 reset, 1 standby, 2 regulator-on, 3 strap-latch, 4 normal, 5 regulator-off. The first power-up path is 0, 1, 2, then 3, then 4. Regulator-on is held until `mainPgood` is sampled high, and it is left on the next clock edge.
- R3: Strap-latch lasts exactly 3*OSC_DIV cycles. On leaving it, the strap pins are copied to the `lat*` outputs. The `lat*` outputs do not change at any other time.
- R4: When `cfgRateBistOk` is low at the latch instant, `latRateCode` becomes 0, which is the slowest rate.
- R5: After the first strap latch, a wake-up goes from regulator-on straight to normal. Strap pin changes no longer reach the `lat*` outputs. Only a reset clears this flag.
- R6: In normal operation, the disable pin high for DEG_CYC consecutive cycles moves the state to regulator-off on the following edge. A high pulse of DEG_CYC-1 cycles has no effect.
- R7: Regulator-off waits while `mainPgood` is high. It enters standby on the edge after `mainPgood` is sampled low.
- R8: In standby, the disable pin low for DEG_CYC consecutive cycles moves the state to regulator-on on the following edge. A low pulse of DEG_CYC-1 cycles has no effect.
- R9: In standby, `lineWake` sampled high moves the state to regulator-on on the next edge. If that wake-up is line-initiated (the filtered pin is high), `disPullDown` is high for exactly PD_CYC cycles from the first normal cycle. The block then returns to regulator-off when the host leaves the pin high.
- R10: While `disPullDown` is high the state stays normal. After a line wake-up with the host holding the pin low, the state stays normal after the pull-down ends.
- R11: `regEnable` is high in regulator-on, strap-latch and normal, and low in the other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mainPgood | input | 1 | Main supply good |
| disLevel | input | 1 | External level on the disable pin (1 = released) |
| lineWake | input | 1 | Wake activity detected on the isolated line |
| cfgMasterSel | input | 1 | Strap: serial-port master role |
| cfgClkPol | input | 1 | Strap: clock polarity |
| cfgClkPha | input | 1 | Strap: clock phase |
| cfgRateCode | input | RATE_W | Strap: clock-rate code |
| cfgRateBistOk | input | 1 | Self-test result of the rate-code comparators |
| pmState | output | 3 | Current power state code |
| regEnable | output | 1 | Regulator enable |
| latMasterSel | output | 1 | Latched master role |
| latClkPol | output | 1 | Latched clock polarity |
| latClkPha | output | 1 | Latched clock phase |
| latRateCode | output | RATE_W | Latched clock-rate code |
| disPullDown | output | 1 | Drive the disable pin low |

## Verification
The assertions assume that `mainPgood` changes only when the regulator state allows it. It rises during regulator-on and falls during regulator-off. They also assume that `lineWake` and `disLevel` are synchronous to `clk`. The stimulus keeps to this. It raises and drops `mainPgood` only after it has seen the matching state at the ports. All inputs change on falling clock edges. Glitch pulses on the disable pin are one cycle shorter than the filter window, so the ignore cases sit right at the boundary.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    PM_RESET   = 3'd0,
    PM_STANDBY = 3'd1,
    PM_REG_ON  = 3'd2,
    PM_CFG     = 3'd3,
    PM_NORMAL  = 3'd4,
    PM_REG_OFF = 3'd5
  } pmState_e;

  // strobes from the sequencer to the counters and strap registers
  typedef struct packed {
    logic cfgCount;   // strap-latch window running
    logic cfgLatch;   // capture straps, set first-power flag
    logic pdStart;    // start the host pull-down timer
  } pmStrobe_t;
endpackage

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int DEG_CYC = 8,
  parameter int PD_CYC  = 40,
  parameter int CFG_CYC = 12,
  parameter int RATE_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmStrobe_t         strobe,
  input  logic              disLevel,
  input  logic              cfgMasterSel,
  input  logic              cfgClkPol,
  input  logic              cfgClkPha,
  input  logic [RATE_W-1:0] cfgRateCode,
  input  logic              cfgRateBistOk,
  output logic              disFilt,
  output logic              cfgDone,
  output logic              pdActive,
  output logic              firstDone,
  output logic              latMasterSel,
  output logic              latClkPol,
  output logic              latClkPha,
  output logic [RATE_W-1:0] latRateCode
);
  localparam int DEG_W = $clog2(DEG_CYC + 1);
  localparam int PD_W  = $clog2(PD_CYC + 1);
  localparam int CFG_W = $clog2(CFG_CYC + 1);
  localparam logic [RATE_W-1:0] SLOWEST_RATE = '0;

  logic [DEG_W-1:0] degCnt;
  logic [PD_W-1:0]  pdCnt;
  logic [CFG_W-1:0] cfgCnt;
  logic             pinNow;

  // the pin as seen on the board: external level, pulled low by our own driver
  assign pdActive = (pdCnt != '0);
  assign pinNow   = disLevel & ~pdActive;
  assign cfgDone  = strobe.cfgCount && (cfgCnt == CFG_W'(CFG_CYC - 1));

  // consecutive-cycle deglitch filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disFilt <= 1'b1;
      degCnt  <= '0;
    end else if (pinNow == disFilt) begin
      degCnt <= '0;
    end else if (degCnt == DEG_W'(DEG_CYC - 1)) begin
      disFilt <= pinNow;
      degCnt  <= '0;
    end else begin
      degCnt <= degCnt + 1'b1;
    end
  end

  // host interrupt pull-down timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pdCnt <= '0;
    else if (strobe.pdStart) pdCnt <= PD_W'(PD_CYC);
    else if (pdActive)       pdCnt <= pdCnt - 1'b1;
  end

  // strap-latch window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   cfgCnt <= '0;
    else if (strobe.cfgCount && !strobe.cfgLatch) cfgCnt <= cfgCnt + 1'b1;
    else                                         cfgCnt <= '0;
  end

  // one-time strap capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstDone    <= 1'b0;
      latMasterSel <= 1'b0;
      latClkPol    <= 1'b0;
      latClkPha    <= 1'b0;
      latRateCode  <= '0;
    end else if (strobe.cfgLatch) begin
      firstDone    <= 1'b1;
      latMasterSel <= cfgMasterSel;
      latClkPol    <= cfgClkPol;
      latClkPha    <= cfgClkPha;
      latRateCode  <= cfgRateBistOk ? cfgRateCode : SLOWEST_RATE;
    end
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mainPgood,
  input  logic      lineWake,
  input  logic      disFilt,
  input  logic      cfgDone,
  input  logic      pdActive,
  input  logic      firstDone,
  output pmState_e  state,
  output logic      regEnable,
  output pmStrobe_t strobe
);
  pmState_e stateNext;
  logic     wakeLine, wakeLineNext;

  always_comb begin
    stateNext    = state;
    wakeLineNext = wakeLine;
    unique case (state)
      PM_RESET: stateNext = PM_STANDBY;
      PM_STANDBY: begin
        if (!firstDone) begin
          stateNext    = PM_REG_ON;
          wakeLineNext = 1'b0;
        end else if (!disFilt || lineWake) begin
          stateNext    = PM_REG_ON;
          wakeLineNext = lineWake && disFilt;
        end
      end
      PM_REG_ON:  if (mainPgood) stateNext = firstDone ? PM_NORMAL : PM_CFG;
      PM_CFG:     if (cfgDone) stateNext = PM_NORMAL;
      PM_NORMAL:  if (disFilt && !pdActive) stateNext = PM_REG_OFF;
      PM_REG_OFF: if (!mainPgood) stateNext = PM_STANDBY;
      default:    stateNext = PM_RESET;
    endcase
  end

  always_comb begin
    strobe.cfgCount = (state == PM_CFG);
    strobe.cfgLatch = (state == PM_CFG) && cfgDone;
    strobe.pdStart  = (state == PM_REG_ON) && mainPgood && firstDone && wakeLine;
  end

  assign regEnable = (state == PM_REG_ON) || (state == PM_CFG) || (state == PM_NORMAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PM_RESET;
      wakeLine <= 1'b0;
    end else begin
      state    <= stateNext;
      wakeLine <= wakeLineNext;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DEG_CYC = 8,
  parameter int PD_CYC  = 40,
  parameter int OSC_DIV = 4,
  parameter int RATE_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mainPgood,
  input  logic              disLevel,
  input  logic              lineWake,
  input  logic              cfgMasterSel,
  input  logic              cfgClkPol,
  input  logic              cfgClkPha,
  input  logic [RATE_W-1:0] cfgRateCode,
  input  logic              cfgRateBistOk,
  output logic [2:0]        pmState,
  output logic              regEnable,
  output logic              latMasterSel,
  output logic              latClkPol,
  output logic              latClkPha,
  output logic [RATE_W-1:0] latRateCode,
  output logic              disPullDown
);
  localparam int CFG_CYC = 3 * OSC_DIV;

  pmStrobe_t strobe;
  pmState_e  state;
  logic      disFilt, cfgDone, pdActive, firstDone;

  pmc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .mainPgood(mainPgood), .lineWake(lineWake),
    .disFilt(disFilt), .cfgDone(cfgDone), .pdActive(pdActive),
    .firstDone(firstDone), .state(state), .regEnable(regEnable), .strobe(strobe)
  );

  pmc_datapath #(
    .DEG_CYC(DEG_CYC), .PD_CYC(PD_CYC), .CFG_CYC(CFG_CYC), .RATE_W(RATE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .disLevel(disLevel),
    .cfgMasterSel(cfgMasterSel), .cfgClkPol(cfgClkPol), .cfgClkPha(cfgClkPha),
    .cfgRateCode(cfgRateCode), .cfgRateBistOk(cfgRateBistOk),
    .disFilt(disFilt), .cfgDone(cfgDone), .pdActive(pdActive),
    .firstDone(firstDone), .latMasterSel(latMasterSel), .latClkPol(latClkPol),
    .latClkPha(latClkPha), .latRateCode(latRateCode)
  );

  assign pmState     = state;
  assign disPullDown = pdActive;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int RATE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              mainPgood,
  input logic [2:0]        pmState,
  input logic              disPullDown,
  input logic              latMasterSel,
  input logic              latClkPol,
  input logic              latClkPha,
  input logic [RATE_W-1:0] latRateCode
);
  a_r2_regon_exit: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == PM_REG_ON && mainPgood) |=> (pmState == PM_CFG || pmState == PM_NORMAL));

  a_r3_straps_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pmState != PM_CFG) |=> $stable({latMasterSel, latClkPol, latClkPha, latRateCode}));

  a_r5_cfg_entry: assert property (@(posedge clk) disable iff (!rstN)
    (pmState != PM_REG_ON && pmState != PM_CFG) |=> (pmState != PM_CFG));

  a_r6_normal_exit: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == PM_NORMAL) |=> (pmState == PM_NORMAL || pmState == PM_REG_OFF));

  a_r7_regoff_wait: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == PM_REG_OFF && mainPgood) |=> (pmState == PM_REG_OFF));

  a_r7_regoff_exit: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == PM_REG_OFF && !mainPgood) |=> (pmState == PM_STANDBY));

  a_r9_pd_normal: assert property (@(posedge clk) disable iff (!rstN)
    disPullDown |-> (pmState == PM_NORMAL));

  a_r10_pd_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (disPullDown && pmState == PM_NORMAL) |=> (pmState == PM_NORMAL));
endmodule

bind pwr_mode_ctrl pmc_checker #(.RATE_W(RATE_W)) chk_i (
  .clk(clk), .rstN(rstN), .mainPgood(mainPgood), .pmState(pmState),
  .disPullDown(disPullDown), .latMasterSel(latMasterSel), .latClkPol(latClkPol),
  .latClkPha(latClkPha), .latRateCode(latRateCode)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int DEG = 4;
  localparam int PD  = 10;
  localparam int OSC = 2;
  localparam int CFG = 3 * OSC;
  localparam int RW  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mainPgood = 1'b0, disLevel = 1'b0, lineWake = 1'b0;
  logic cfgMasterSel = 1'b1, cfgClkPol = 1'b1, cfgClkPha = 1'b0, cfgRateBistOk = 1'b1;
  logic [RW-1:0] cfgRateCode = 2'd2;
  logic [2:0] pmState;
  logic regEnable, latMasterSel, latClkPol, latClkPha, disPullDown;
  logic [RW-1:0] latRateCode;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  pwr_mode_ctrl #(.DEG_CYC(DEG), .PD_CYC(PD), .OSC_DIV(OSC), .RATE_W(RW)) dut_i (
    .clk(clk), .rstN(rstN), .mainPgood(mainPgood), .disLevel(disLevel),
    .lineWake(lineWake), .cfgMasterSel(cfgMasterSel), .cfgClkPol(cfgClkPol),
    .cfgClkPha(cfgClkPha), .cfgRateCode(cfgRateCode), .cfgRateBistOk(cfgRateBistOk),
    .pmState(pmState), .regEnable(regEnable), .latMasterSel(latMasterSel),
    .latClkPol(latClkPol), .latClkPha(latClkPha), .latRateCode(latRateCode),
    .disPullDown(disPullDown)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int  mSt = 0, mDeg = 0, mCfg = 0, mPd = 0, mRate = 0, nSt = 0;
  bit  mFilt = 1, mFirst = 0, mWl = 0, mMas = 0, mPol = 0, mPha = 0;
  bit  pin, oFilt, doLatch, doStart;
  int  oPd;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mDeg = 0; mCfg = 0; mPd = 0; mRate = 0;
      mFilt = 1; mFirst = 0; mWl = 0; mMas = 0; mPol = 0; mPha = 0;
    end else begin
      pin = disLevel && (mPd == 0);
      oFilt = mFilt; oPd = mPd; nSt = mSt; doLatch = 0; doStart = 0;
      if (pin == mFilt) mDeg = 0;
      else if (mDeg == DEG - 1) begin mFilt = pin; mDeg = 0; end
      else mDeg++;
      case (mSt)
        0: nSt = 1;
        1: if (!mFirst) begin nSt = 2; mWl = 0; end
           else if (!oFilt || lineWake) begin nSt = 2; mWl = lineWake && oFilt; end
        2: if (mainPgood) begin
             if (mFirst) begin nSt = 4; doStart = mWl; end else nSt = 3;
           end
        3: if (mCfg == CFG - 1) begin nSt = 4; doLatch = 1; end
        4: if (oFilt && oPd == 0) nSt = 5;
        5: if (!mainPgood) nSt = 1;
        default: nSt = 0;
      endcase
      mCfg = (mSt == 3 && !doLatch) ? mCfg + 1 : 0;
      if (doStart) mPd = PD; else if (mPd > 0) mPd--;
      if (doLatch) begin
        mFirst = 1; mMas = cfgMasterSel; mPol = cfgClkPol; mPha = cfgClkPha;
        mRate = cfgRateBistOk ? int'(cfgRateCode) : 0;
      end
      mSt = nSt;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R2 state vs model", int'(pmState), mSt);
      check("R11 regEnable vs model", int'(regEnable), int'(mSt == 2 || mSt == 3 || mSt == 4));
      check("R9 disPullDown vs model", int'(disPullDown), int'(mPd != 0));
      check("R3 straps vs model", int'({latMasterSel, latClkPol, latClkPha, latRateCode}),
            int'({mMas, mPol, mPha, mRate[RW-1:0]}));
    end
  end

  task automatic waitState(input int code, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (int'(pmState) != code && n < 2000);
  endtask

  initial begin
    int n;
    // R1 reset
    repeat (3) @(negedge clk);
    check("R1 state in reset", int'(pmState), 0);
    check("R1 regEnable in reset", int'(regEnable), 0);
    check("R1 pulldown in reset", int'(disPullDown), 0);
    check("R1 straps in reset", int'({latMasterSel, latClkPol, latClkPha, latRateCode}), 0);
    rstN = 1'b1;
    // R2 first power-up
    waitState(1, n); check("R2 reaches standby", n, 1);
    waitState(2, n); check("R2 reaches regulator-on", n, 1);
    repeat (5) @(negedge clk);
    check("R2 waits for power-good", int'(pmState), 2);
    check("R11 regEnable in regulator-on", int'(regEnable), 1);
    mainPgood = 1'b1;
    waitState(3, n); check("R2 enters strap-latch", n, 1);
    waitState(4, n); check("R3 strap-latch length", n, CFG);
    check("R3 master", int'(latMasterSel), 1);
    check("R3 polarity", int'(latClkPol), 1);
    check("R3 phase", int'(latClkPha), 0);
    check("R3 rate", int'(latRateCode), 2);
    // R6 glitch then sleep
    disLevel = 1'b1; repeat (DEG - 1) @(negedge clk); disLevel = 1'b0;
    repeat (DEG + 2) @(negedge clk);
    check("R6 short high pulse ignored", int'(pmState), 4);
    disLevel = 1'b1;
    waitState(5, n); check("R6 sleep after deglitch", n, DEG + 1);
    check("R11 regEnable off", int'(regEnable), 0);
    repeat (3) @(negedge clk);
    check("R7 regulator-off waits", int'(pmState), 5);
    mainPgood = 1'b0;
    waitState(1, n); check("R7 enters standby", n, 1);
    // R8 host wake, R5 no re-latch
    cfgMasterSel = 1'b0; cfgClkPol = 1'b0; cfgClkPha = 1'b1; cfgRateCode = 2'd1;
    disLevel = 1'b0; repeat (DEG - 1) @(negedge clk); disLevel = 1'b1;
    repeat (DEG + 2) @(negedge clk);
    check("R8 short low pulse ignored", int'(pmState), 1);
    disLevel = 1'b0;
    waitState(2, n); check("R8 host wake after deglitch", n, DEG + 1);
    mainPgood = 1'b1;
    waitState(4, n); check("R5 strap-latch skipped", n, 1);
    check("R5 straps unchanged", int'({latMasterSel, latClkPol, latClkPha, latRateCode}),
          int'({1'b1, 1'b1, 1'b0, 2'd2}));
    check("R9 no pulldown on host wake", int'(disPullDown), 0);
    disLevel = 1'b1; waitState(5, n); mainPgood = 1'b0; waitState(1, n);
    // R9 line wake with host released
    lineWake = 1'b1; @(negedge clk); lineWake = 1'b0;
    check("R9 line wake", int'(pmState), 2);
    mainPgood = 1'b1;
    waitState(4, n);
    check("R9 pulldown on entry", int'(disPullDown), 1);
    n = 0; while (disPullDown && n < 1000) begin @(negedge clk); n++; end
    check("R9 pulldown length", n, PD);
    waitState(5, n); check("R9 back to sleep", int'(n <= 2 * DEG + 2), 1);
    mainPgood = 1'b0; waitState(1, n);
    // R10 line wake with host holding low
    lineWake = 1'b1; @(negedge clk); lineWake = 1'b0; disLevel = 1'b0;
    mainPgood = 1'b1;
    waitState(4, n);
    repeat (PD + 3 * DEG) @(negedge clk);
    check("R10 stays normal", int'(pmState), 4);
    check("R10 pulldown released", int'(disPullDown), 0);
    disLevel = 1'b1; waitState(5, n); mainPgood = 1'b0; waitState(1, n);
    // R4 and R5: reset clears the flag, failed self-test picks slowest code
    rstN = 1'b0; cfgMasterSel = 1'b1; cfgRateCode = 2'd3; cfgRateBistOk = 1'b0;
    disLevel = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 straps cleared by reset", int'(latMasterSel), 0);
    rstN = 1'b1;
    waitState(2, n);
    mainPgood = 1'b1;
    waitState(3, n); check("R5 strap-latch again after reset", n, 1);
    waitState(4, n);
    check("R4 rate falls back to slowest", int'(latRateCode), 0);
    check("R3 master after reset", int'(latMasterSel), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule